// File: doc/BRIEF.md
# Synchronous Serial Audio Port (word level)

This block is the word-level core of a synchronous serial audio port attached to a DSP core. It holds a transmit data register and a receive data register and formats words between them and a serial engine outside the block. The word length can be 8, 12, 16 or 24 bits, and the bit order can optionally be reversed within that length. The serial engine pulses `txStrobe` once per outgoing word and takes the formatted word from `txWord`. It pulses `rxStrobe` once per incoming word with the word on `rxWord`. Two frame-sync inputs report the start of a frame for each direction.

The block keeps the status flags the DSP core polls: transmit empty, receive full, and one frame-sync flag per direction. It also raises one-cycle interrupt requests. When a direction is switched on, it stays silent until a frame begins. While waiting it sends zeros and stores zeros instead of data. In network mode, a frame sync with value 1 ends the wait. The clock direction, sync mode and frame-rate divider are decoded here and passed on to the clock generator.

Top module: `serial_audio_port`

## Requirements
- R1: After reset, `status` reads 0x40 (only the transmit-empty flag set), `txWord` and `rxData` are zero, `rateDiv` is 1, both interrupt outputs are low, and both directions are waiting for a frame.
- R2: A write of `cfgAData` on `cfgAWrEn` stores two fields. Bits [6:5] are the word-length code: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24. Bits [4:0] are the divider code, and `rateDiv` equals that code plus 1.
- R3: A write of `cfgBData` on `cfgBWrEn` stores these single-bit fields: bit0 clock direction (driven on `clkDir`), bit1 reversed bit order, bit2 sync mode (driven on `syncMode`), bit3 network mode, bit4 transmit enable, bit5 receive enable, bit6 transmit interrupt enable, bit7 receive interrupt enable.
- R4: When a `cfgB` write changes transmit enable (or receive enable) from 0 to 1, that direction starts waiting for a frame. While a direction waits, a transmit strobe drives `txWord` to zero and a receive strobe loads `rxData` with zero, and neither raises an interrupt.
- R5: In network mode, a frame-sync strobe with value 1 sets that direction's flag (status bit2 for receive, bit3 for transmit) and ends its wait. A frame-sync strobe with value 0 clears the flag.
- R6: In normal mode (bit3 clear), any frame-sync strobe sets that direction's flag and does not end the wait.
- R7: On a receive strobe with receive enabled and not waiting, `rxData` becomes the low word-length bits of `rxWord` placed in the top bits of the 24-bit register, with zeros below. The bits are first reversed within the word length when the reverse bit is set. `rxData` changes only on a receive strobe.
- R8: On a transmit strobe with transmit enabled and not waiting, `txWord` becomes the top word-length bits of the transmit register moved to the bottom, with zeros above. The bits are reversed within the word length when the reverse bit is set. `txWord` changes only on a transmit strobe.
- R9: `txIrq` (or `rxIrq`) pulses high for one cycle after a transmit (or receive) strobe that delivers data while the matching interrupt-enable bit is set, and is otherwise low.
- R10: A transmit strobe sets the transmit-empty flag (status bit6), and `txWrEn` or `slotWrEn` clears it. A receive strobe sets the receive-full flag (status bit7), and `rxRdEn` clears it. A clear in the same cycle as a set wins.
- R11: With a direction disabled, its strobe outputs or stores zero and raises no interrupt, but still updates its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAWrEn | input | 1 | Write strobe for configuration word A |
| cfgAData | input | 7 | Word-length code [6:5] and divider code [4:0] |
| cfgBWrEn | input | 1 | Write strobe for configuration word B |
| cfgBData | input | 8 | Mode and enable bits |
| txWrEn | input | 1 | Write the transmit register |
| txWrData | input | 24 | Data written to the transmit register |
| slotWrEn | input | 1 | Dummy write that only clears transmit-empty |
| rxRdEn | input | 1 | Receive register read, clears receive-full |
| txStrobe | input | 1 | One pulse per transmitted word |
| rxStrobe | input | 1 | One pulse per received word |
| rxWord | input | 24 | Received word, right-justified |
| rxFsStrobe | input | 1 | Receive frame-sync event |
| rxFsVal | input | 1 | Receive frame-sync value |
| txFsStrobe | input | 1 | Transmit frame-sync event |
| txFsVal | input | 1 | Transmit frame-sync value |
| txWord | output | 24 | Formatted outgoing word, right-justified |
| rxData | output | 24 | Receive register contents |
| status | output | 8 | Flags: bit7 receive full, bit6 transmit empty, bit3 transmit frame, bit2 receive frame |
| txIrq | output | 1 | Transmit interrupt request pulse |
| rxIrq | output | 1 | Receive interrupt request pulse |
| rateDiv | output | 6 | Frame-rate divider value |
| clkDir | output | 1 | Clock direction bit |
| syncMode | output | 1 | Sync mode bit |

## Verification
If a wait state is wrong, the next strobe in that direction shows it at once. The strobe produces either zeros where data was expected or data where zeros were expected, and the interrupt pulse appears or is missing in the following cycle. If the word-length code or the reverse bit is held wrongly, every formatted word is wrong. The bench therefore sweeps all four lengths, both bit orders and several data patterns, so a fault shows on the first word of the affected setting. A wrong flag shows in `status` one cycle after the strobe or access that should have changed it.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int WORD_W = 24;
  localparam int DIV_W = 5;
  localparam int WL_CODE_W = 2;
  localparam int LEN_W = $clog2(WORD_W + 1);

  typedef struct packed {
    logic rxIrqEn;
    logic txIrqEn;
    logic rxEn;
    logic txEn;
    logic netMode;
    logic syncMode;
    logic revOrder;
    logic clkDir;
  } ctlB_t;

  typedef struct packed {
    logic                 rxAccept;
    logic                 txAccept;
    logic                 revOrder;
    logic [WL_CODE_W-1:0] wlCode;
  } dpCtrl_t;

  function automatic logic [LEN_W-1:0] wordBits(input logic [WL_CODE_W-1:0] code);
    case (code)
      2'd0:    wordBits = LEN_W'(8);
      2'd1:    wordBits = LEN_W'(12);
      2'd2:    wordBits = LEN_W'(16);
      default: wordBits = LEN_W'(WORD_W);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] wordMask(input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i < int'(len));
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] revWithin(input logic [WORD_W-1:0] x,
                                                  input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(len)) r[i] = x[int'(len) - 1 - i];
    end
    return r;
  endfunction
endpackage

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgAWrEn,
  input  logic [6:0]         cfgAData,
  input  logic               cfgBWrEn,
  input  logic [7:0]         cfgBData,
  input  logic               txWrEn,
  input  logic               slotWrEn,
  input  logic               rxRdEn,
  input  logic               txStrobe,
  input  logic               rxStrobe,
  input  logic               rxFsStrobe,
  input  logic               rxFsVal,
  input  logic               txFsStrobe,
  input  logic               txFsVal,
  output dpCtrl_t            dpCtrl,
  output logic [7:0]         status,
  output logic               txIrq,
  output logic               rxIrq,
  output logic [DIV_W:0]     rateDiv,
  output logic               clkDir,
  output logic               syncMode
);
  localparam int TDE_BIT = 6;
  localparam int RDF_BIT = 7;
  localparam int RFS_BIT = 2;
  localparam int TFS_BIT = 3;

  ctlB_t                ctlB;
  ctlB_t                ctlBNew;
  logic [WL_CODE_W-1:0] wlCode;
  logic [DIV_W-1:0]     dcCode;
  logic                 txWait, rxWait;
  logic                 tdeFlag, rdfFlag, rfsFlag, tfsFlag;
  logic                 txAccept, rxAccept;

  assign ctlBNew  = ctlB_t'(cfgBData);
  assign txAccept = ctlB.txEn && !txWait;
  assign rxAccept = ctlB.rxEn && !rxWait;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wlCode  <= '0;
      dcCode  <= '0;
      ctlB    <= '0;
      txWait  <= 1'b1;
      rxWait  <= 1'b1;
      tdeFlag <= 1'b1;
      rdfFlag <= 1'b0;
      rfsFlag <= 1'b0;
      tfsFlag <= 1'b0;
      txIrq   <= 1'b0;
      rxIrq   <= 1'b0;
    end else begin
      if (cfgAWrEn) begin
        dcCode <= cfgAData[DIV_W-1:0];
        wlCode <= cfgAData[DIV_W+WL_CODE_W-1:DIV_W];
      end
      if (cfgBWrEn) ctlB <= ctlBNew;

      if (cfgBWrEn && ctlBNew.txEn && !ctlB.txEn) txWait <= 1'b1;
      else if (txFsStrobe && ctlB.netMode && txFsVal) txWait <= 1'b0;

      if (cfgBWrEn && ctlBNew.rxEn && !ctlB.rxEn) rxWait <= 1'b1;
      else if (rxFsStrobe && ctlB.netMode && rxFsVal) rxWait <= 1'b0;

      if (rxFsStrobe) rfsFlag <= ctlB.netMode ? rxFsVal : 1'b1;
      if (txFsStrobe) tfsFlag <= ctlB.netMode ? txFsVal : 1'b1;

      if (txWrEn || slotWrEn) tdeFlag <= 1'b0;
      else if (txStrobe)      tdeFlag <= 1'b1;

      if (rxRdEn)        rdfFlag <= 1'b0;
      else if (rxStrobe) rdfFlag <= 1'b1;

      txIrq <= txStrobe && txAccept && ctlB.txIrqEn;
      rxIrq <= rxStrobe && rxAccept && ctlB.rxIrqEn;
    end
  end

  always_comb begin
    status          = '0;
    status[TDE_BIT] = tdeFlag;
    status[RDF_BIT] = rdfFlag;
    status[RFS_BIT] = rfsFlag;
    status[TFS_BIT] = tfsFlag;
  end

  assign dpCtrl.rxAccept = rxAccept;
  assign dpCtrl.txAccept = txAccept;
  assign dpCtrl.revOrder = ctlB.revOrder;
  assign dpCtrl.wlCode   = wlCode;

  assign rateDiv  = {1'b0, dcCode} + 1'b1;
  assign clkDir   = ctlB.clkDir;
  assign syncMode = ctlB.syncMode;
endmodule

// File: rtl/sap_datapath.sv
module sap_datapath
  import sap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic              txWrEn,
  input  logic [WORD_W-1:0] txWrData,
  input  logic              txStrobe,
  input  logic              rxStrobe,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxData
);
  logic [LEN_W-1:0]  len;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] rxLow, rxOrdered, rxJustified;
  logic [WORD_W-1:0] txLow, txFormatted;

  assign len  = wordBits(dpCtrl.wlCode);
  assign mask = wordMask(len);

  // Receive: order within the word, then move to the top of the register.
  assign rxLow       = rxWord & mask;
  assign rxOrdered   = dpCtrl.revOrder ? revWithin(rxLow, len) : rxLow;
  assign rxJustified = rxOrdered << (LEN_W'(WORD_W) - len);

  // Transmit: take the top bits down to the bottom, then order.
  assign txLow       = (txReg >> (LEN_W'(WORD_W) - len)) & mask;
  assign txFormatted = dpCtrl.revOrder ? revWithin(txLow, len) : txLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg  <= '0;
      txWord <= '0;
      rxData <= '0;
    end else begin
      if (txWrEn)   txReg  <= txWrData;
      if (txStrobe) txWord <= dpCtrl.txAccept ? txFormatted : '0;
      if (rxStrobe) rxData <= dpCtrl.rxAccept ? rxJustified : '0;
    end
  end
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgAWrEn,
  input  logic [6:0]        cfgAData,
  input  logic              cfgBWrEn,
  input  logic [7:0]        cfgBData,
  input  logic              txWrEn,
  input  logic [WORD_W-1:0] txWrData,
  input  logic              slotWrEn,
  input  logic              rxRdEn,
  input  logic              txStrobe,
  input  logic              rxStrobe,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              rxFsStrobe,
  input  logic              rxFsVal,
  input  logic              txFsStrobe,
  input  logic              txFsVal,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxData,
  output logic [7:0]        status,
  output logic              txIrq,
  output logic              rxIrq,
  output logic [DIV_W:0]    rateDiv,
  output logic              clkDir,
  output logic              syncMode
);
  dpCtrl_t dpCtrl;

  sap_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgAWrEn(cfgAWrEn), .cfgAData(cfgAData),
    .cfgBWrEn(cfgBWrEn), .cfgBData(cfgBData),
    .txWrEn(txWrEn), .slotWrEn(slotWrEn), .rxRdEn(rxRdEn),
    .txStrobe(txStrobe), .rxStrobe(rxStrobe),
    .rxFsStrobe(rxFsStrobe), .rxFsVal(rxFsVal),
    .txFsStrobe(txFsStrobe), .txFsVal(txFsVal),
    .dpCtrl(dpCtrl), .status(status),
    .txIrq(txIrq), .rxIrq(rxIrq),
    .rateDiv(rateDiv), .clkDir(clkDir), .syncMode(syncMode)
  );

  sap_datapath uData (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl),
    .txWrEn(txWrEn), .txWrData(txWrData),
    .txStrobe(txStrobe), .rxStrobe(rxStrobe), .rxWord(rxWord),
    .txWord(txWord), .rxData(rxData)
  );
endmodule

// File: rtl/sap_checker.sv
module sap_checker (
  input logic        clk,
  input logic        rstN,
  input logic        txWrEn,
  input logic        slotWrEn,
  input logic        rxRdEn,
  input logic        txStrobe,
  input logic        rxStrobe,
  input logic [23:0] txWord,
  input logic [23:0] rxData,
  input logic [7:0]  status,
  input logic        txIrq,
  input logic        rxIrq,
  input logic [5:0]  rateDiv
);
  assert_tde_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txStrobe && !txWrEn && !slotWrEn) |=> status[6]);
  assert_tde_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn || slotWrEn) |=> !status[6]);
  assert_rdf_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && !rxRdEn) |=> status[7]);
  assert_rdf_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxRdEn |=> !status[7]);
  assert_tx_irq_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(txStrobe));
  assert_rx_irq_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(rxStrobe));
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txStrobe |=> $stable(txWord));
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rxStrobe |=> $stable(rxData));
  assert_div_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rateDiv != 6'd0);
endmodule

bind serial_audio_port sap_checker uChk (
  .clk(clk), .rstN(rstN), .txWrEn(txWrEn), .slotWrEn(slotWrEn),
  .rxRdEn(rxRdEn), .txStrobe(txStrobe), .rxStrobe(rxStrobe),
  .txWord(txWord), .rxData(rxData), .status(status),
  .txIrq(txIrq), .rxIrq(rxIrq), .rateDiv(rateDiv)
);

// File: tb/tb_serial_audio_port.sv
module tb_serial_audio_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgAWrEn = 0, cfgBWrEn = 0, txWrEn = 0, slotWrEn = 0, rxRdEn = 0;
  logic [6:0]  cfgAData = '0;
  logic [7:0]  cfgBData = '0;
  logic [23:0] txWrData = '0, rxWord = '0;
  logic        txStrobe = 0, rxStrobe = 0;
  logic        rxFsStrobe = 0, rxFsVal = 0, txFsStrobe = 0, txFsVal = 0;
  logic [23:0] txWord, rxData;
  logic [7:0]  status;
  logic        txIrq, rxIrq, clkDir, syncMode;
  logic [5:0]  rateDiv;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_audio_port dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Each access is a one-cycle pulse; results are read at the following negedge.
  task automatic wrA(input logic [6:0] v);
    @(negedge clk); cfgAWrEn = 1; cfgAData = v; @(negedge clk); cfgAWrEn = 0;
  endtask
  task automatic wrB(input logic [7:0] v);
    @(negedge clk); cfgBWrEn = 1; cfgBData = v; @(negedge clk); cfgBWrEn = 0;
  endtask
  task automatic wrTx(input logic [23:0] v);
    @(negedge clk); txWrEn = 1; txWrData = v; @(negedge clk); txWrEn = 0;
  endtask
  task automatic slotWr();
    @(negedge clk); slotWrEn = 1; @(negedge clk); slotWrEn = 0;
  endtask
  task automatic rdRx();
    @(negedge clk); rxRdEn = 1; @(negedge clk); rxRdEn = 0;
  endtask
  task automatic txStb();
    @(negedge clk); txStrobe = 1; @(negedge clk); txStrobe = 0;
  endtask
  task automatic rxStb(input logic [23:0] v);
    @(negedge clk); rxStrobe = 1; rxWord = v; @(negedge clk); rxStrobe = 0;
  endtask
  task automatic rxFs(input logic v);
    @(negedge clk); rxFsStrobe = 1; rxFsVal = v; @(negedge clk); rxFsStrobe = 0;
  endtask
  task automatic txFs(input logic v);
    @(negedge clk); txFsStrobe = 1; txFsVal = v; @(negedge clk); txFsStrobe = 0;
  endtask

  function automatic int lenOf(input int code);
    return (code == 0) ? 8 : (code == 1) ? 12 : (code == 2) ? 16 : 24;
  endfunction
  function automatic logic [23:0] revN(input logic [23:0] x, input int n);
    logic [23:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = x[n-1-i];
    return r;
  endfunction
  function automatic logic [23:0] rxExp(input logic [23:0] d, input int n, input bit rev);
    logic [23:0] low = d & ((24'h1 << n) - 1);
    if (n == 24) low = d;
    if (rev) low = revN(low, n);
    return low << (24 - n);
  endfunction
  function automatic logic [23:0] txExp(input logic [23:0] d, input int n, input bit rev);
    logic [23:0] low = d >> (24 - n);
    return rev ? revN(low, n) : low;
  endfunction

  // cfgB bits: 0 clkDir, 1 reverse, 2 sync, 3 network, 4 TE, 5 RE, 6 TIE, 7 RIE
  localparam logic [7:0] NET = 8'h08, TE = 8'h10, RE = 8'h20, TIE = 8'h40, RIE = 8'h80;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [23:0] pats [4];
    pats[0] = 24'hABCDEF; pats[1] = 24'h123456; pats[2] = 24'hF0F0A5; pats[3] = 24'h800001;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 status", status, 8'h40);
    chk("R1 txWord", txWord, 0);
    chk("R1 rxData", rxData, 0);
    chk("R1 rateDiv", rateDiv, 1);
    chk("R1 irqs", {txIrq, rxIrq}, 0);

    // R2: divider code
    wrA(7'd5);  chk("R2 rateDiv 6", rateDiv, 6);
    wrA(7'd31); chk("R2 rateDiv 32", rateDiv, 32);
    wrA(7'd0);  chk("R2 rateDiv 1", rateDiv, 1);

    // R3: pass-through bits
    wrB(8'h01); chk("R3 clkDir", {clkDir, syncMode}, 2'b10);
    wrB(8'h04); chk("R3 syncMode", {clkDir, syncMode}, 2'b01);

    // R4/R6: enable in normal mode; directions wait, normal-mode sync never releases
    wrB(TE | RE | TIE | RIE);
    wrTx(24'hABCDEF);
    txStb();
    chk("R4 tx zero while waiting", txWord, 0);
    chk("R4 no tx irq while waiting", txIrq, 0);
    rxStb(24'h5A);
    chk("R4 rx zero while waiting", rxData, 0);
    chk("R4 no rx irq while waiting", rxIrq, 0);
    chk("R10 rdf set after strobe", status[7], 1);
    rxFs(1'b0); chk("R6 rfs set by value 0", status[2], 1);
    txFs(1'b0); chk("R6 tfs set by value 0", status[3], 1);
    rxStb(24'h5A); chk("R6 rx still waiting", rxData, 0);
    txStb();       chk("R6 tx still waiting", txWord, 0);

    // R5: network mode (TE/RE stay set, no new wait)
    wrB(NET | TE | RE | TIE | RIE);
    rxFs(1'b0); chk("R5 rfs cleared", status[2], 0);
    txFs(1'b0); chk("R5 tfs cleared", status[3], 0);
    txStb();    chk("R5 tx still waits after value 0", txWord, 0);
    rxFs(1'b1); chk("R5 rfs set", status[2], 1);
    txFs(1'b1); chk("R5 tfs set", status[3], 1);

    // R7/R8/R9: sweep word lengths, bit order and data
    for (int wl = 0; wl < 4; wl++) begin
      for (int rev = 0; rev < 2; rev++) begin
        wrA(7'(wl << 5));
        wrB(NET | TE | RE | TIE | RIE | 8'(rev << 1));
        for (int p = 0; p < 4; p++) begin
          wrTx(pats[p]);
          txStb();
          chk("R8 tx format", txWord, txExp(pats[p], lenOf(wl), rev[0]));
          chk("R9 tx irq", txIrq, 1);
          chk("R10 tde set", status[6], 1);
          rxStb(pats[p]);
          chk("R7 rx format", rxData, rxExp(pats[p], lenOf(wl), rev[0]));
          chk("R9 rx irq", rxIrq, 1);
        end
      end
    end

    // R10: flag clears, clear wins over set
    wrTx(24'h1); chk("R10 tde cleared by write", status[6], 0);
    txStb();     chk("R10 tde set by strobe", status[6], 1);
    slotWr();    chk("R10 tde cleared by dummy write", status[6], 0);
    rdRx();      chk("R10 rdf cleared by read", status[7], 0);
    @(negedge clk); rxStrobe = 1; rxRdEn = 1; rxWord = 24'h3C;
    @(negedge clk); rxStrobe = 0; rxRdEn = 0;
    chk("R10 read beats strobe", status[7], 0);

    // R9: interrupt enables off -> no pulses while data flows
    wrA(7'(3 << 5));
    wrB(NET | TE | RE);
    wrTx(24'h654321);
    txStb();        chk("R9 tx data w/o irq", txWord, 24'h654321);
    chk("R9 no tx irq when disabled", txIrq, 0);
    rxStb(24'h777); chk("R9 no rx irq when disabled", rxIrq, 0);

    // R11: directions disabled
    wrB(NET | TIE | RIE);
    txStb();        chk("R11 tx zero when disabled", txWord, 0);
    chk("R11 no tx irq", txIrq, 0);
    chk("R11 tde still set", status[6], 1);
    rxStb(24'h777); chk("R11 rx zero when disabled", rxData, 0);
    chk("R11 no rx irq", rxIrq, 0);

    // R4: re-enable sets wait again until network sync 1
    wrB(NET | TE | RE | TIE | RIE);
    txStb();        chk("R4 tx waits after re-enable", txWord, 0);
    rxStb(24'h777); chk("R4 rx waits after re-enable", rxData, 0);
    txFs(1'b1);
    rxFs(1'b1);
    txStb();        chk("R4 tx released", txWord, 24'h654321);
    rxStb(24'h777); chk("R4 rx released", rxData, 24'h000777);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule